// File: doc/BRIEF.md
# Timed Task Sequencer with Abort

This block is a small single-clock controller that runs one timed activity per request. When it sees a start request while resting, it enters a running phase whose length is a fixed number of clock cycles set by a parameter (one hundred by default). At the end of the run it passes through a wrap-up state. In that state a registered completion pulse, one cycle wide, appears on the output. The controller then rests again.

An external stop input cuts a run short. The controller then parks in a halted state for as long as the stop input stays high, and it returns to rest only after the input is released. A run that ends this way never produces the completion pulse. Start requests that arrive while the controller is not resting are ignored. Both request inputs are assumed to be synchronous to the clock already.

Top module: `timed_sequencer`

## Requirements
- R1: A high `rst` sampled at a rising edge puts the controller at rest and drives `done` low at that edge. A run in progress is discarded and gives no later pulse.
- R2: A high `go` sampled at rest starts a run. `done` goes high right after the edge that comes INTERVAL+1 edges after the edge that sampled `go`.
- R3: `done` comes from a flip-flop. It is high for exactly one cycle per completed run, and low in every other cycle.
- R4: A high `kill` sampled at any edge during a run ends the run in the halted state, and no `done` pulse follows.
- R5: The controller stays halted while `kill` is high, and it ignores `go` during that time. The edge that samples `kill` low returns it to rest. A `go` held high across the release therefore gives `done` INTERVAL+2 edges after that edge.
- R6: When `kill` is sampled at the same edge at which the run's last cycle ends, the stop takes priority: the controller halts and gives no `done` pulse.
- R7: `go` is ignored while running, while wrapping up and while halted. With `go` held high all the time, successive `done` pulses are exactly INTERVAL+2 cycles apart.
- R8: The interval counter restarts from zero on every new run. A run that follows an aborted run at any point has the full INTERVAL+1 latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, acted on only at rest |
| kill | input | 1 | Stop request; aborts a run and holds the halted state while high |
| done | output | 1 | Registered one-cycle completion pulse |

## Verification
The only output is `done`, so any fault in the state or the counter must show up as a pulse that comes early, late, twice or not at all. The bench makes a fault of this kind visible within one run length, or about INTERVAL+2 cycles. Stop requests are swept across every cycle of a run, including the cycle that ends it. Each abort is followed by a fresh start whose latency is measured, which exposes a counter that was not cleared or a halted state that was left too early. A continuously held start request measures the pulse period, and that period reveals whether starts are accepted outside the resting state.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_WRAP = 2'd2,
        SEQ_HALT = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic go;
        logic kill;
        logic expired;
    } seq_cond_t;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int INTERVAL = 100,
    parameter int CW       = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          advance,
    output logic [CW-1:0] count_o,
    output logic          expired
);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] count_q;

    assign expired = (count_q == LAST);
    assign count_o = count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (advance && !expired) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
(
    input  seq_state_t cur,
    input  seq_cond_t  cond,
    output seq_state_t nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            SEQ_IDLE: if (cond.go) nxt = SEQ_RUN;
            SEQ_RUN: begin
                if (cond.kill)         nxt = SEQ_HALT;
                else if (cond.expired) nxt = SEQ_WRAP;
            end
            SEQ_WRAP: nxt = SEQ_IDLE;
            SEQ_HALT: if (!cond.kill) nxt = SEQ_IDLE;
            default:  nxt = SEQ_IDLE;
        endcase
    end
endmodule

// File: rtl/seq_done_reg.sv
module seq_done_reg
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_t nxt,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= (nxt == SEQ_WRAP);
    end
endmodule

// File: rtl/timed_sequencer.sv
module timed_sequencer
    import seq_pkg::*;
#(
    parameter int INTERVAL = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic kill,
    output logic done
);
    localparam int CW = cnt_width(INTERVAL);

    seq_state_t    state_q;
    seq_state_t    state_d;
    seq_cond_t     cond;
    logic [CW-1:0] tick_cnt;
    logic          expired;

    seq_timer #(.INTERVAL(INTERVAL), .CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q != SEQ_RUN),
        .advance (state_q == SEQ_RUN),
        .count_o (tick_cnt),
        .expired (expired)
    );

    always_comb begin
        cond.go      = go;
        cond.kill    = kill;
        cond.expired = expired;
    end

    seq_next u_next (
        .cur  (state_q),
        .cond (cond),
        .nxt  (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    seq_done_reg u_done (
        .clk  (clk),
        .rst  (rst),
        .nxt  (state_d),
        .done (done)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
#(
    parameter int INTERVAL = 100,
    parameter int CW       = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          go,
    input logic          kill,
    input logic          done,
    input seq_state_t    state,
    input logic [CW-1:0] count
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state == SEQ_IDLE && !done));

    assert_go_starts_R2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && go) |=> (state == SEQ_RUN));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_in_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == SEQ_WRAP));

    assert_kill_halts_R4: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && kill) |=> (state == SEQ_HALT && !done));

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HALT && kill) |=> (state == SEQ_HALT));

    assert_halt_release_R5: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_HALT && !kill) |=> (state == SEQ_IDLE));

    assert_finish_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && !kill && count == CW'(INTERVAL - 1)) |=> done);

    assert_wrap_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WRAP) |=> (state == SEQ_IDLE));

    assert_count_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && go) |=> (count == '0));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(INTERVAL - 1));
endmodule

bind timed_sequencer seq_checker #(.INTERVAL(INTERVAL), .CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .kill  (kill),
    .done  (done),
    .state (state_q),
    .count (tick_cnt)
);

// File: tb/timed_sequencer_test.sv
module timed_sequencer_test;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic kill = 1'b0;
    logic done;

    int checks = 0;
    int errors = 0;

    timed_sequencer #(.INTERVAL(N)) uut (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .kill (kill),
        .done (done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Assert go, release it after the first edge, and count edges until done rises.
    task automatic start_measure(output int lat);
        go = 1'b1;
        lat = 0;
        do begin
            step();
            lat++;
            go = 1'b0;
        end while (!done && lat < 4 * N);
    endtask

    // Count edges until done rises, with go left as it is.
    task automatic wait_done(output int lat);
        lat = 0;
        do begin
            step();
            lat++;
        end while (!done && lat < 4 * N);
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        int seen;

        // R1: reset with go high holds rest and done low
        go = 1'b1;
        repeat (3) step();
        check(done == 1'b0, "R1 reset done low", done, 0);
        go = 1'b0;
        rst = 1'b0;
        step();
        check(done == 1'b0, "R1 after reset", done, 0);

        // R2, R3: basic run latency and pulse width
        start_measure(lat);
        check(lat == N + 1, "R2 latency", lat, N + 1);
        step();
        check(done == 1'b0, "R3 pulse width", done, 0);
        step();
        start_measure(lat);
        check(lat == N + 1, "R2 second run", lat, N + 1);
        step();
        check(done == 1'b0, "R3 second width", done, 0);

        // R4, R6, R8: stop after every edge of a run
        for (int k = 1; k <= N; k++) begin
            go = 1'b1;
            step();
            go = 1'b0;
            for (int j = 1; j < k; j++) step();
            kill = 1'b1;
            seen = 0;
            for (int j = 0; j < N + 3; j++) begin
                step();
                if (done) seen++;
            end
            if (k == N) check(seen == 0, "R6 kill at completion", seen, 0);
            else        check(seen == 0, "R4 kill aborts", seen, 0);
            kill = 1'b0;
            step();
            start_measure(lat);
            check(lat == N + 1, "R8 run after abort", lat, N + 1);
            step();
            check(done == 1'b0, "R3 width after abort", done, 0);
        end

        // R5: halt holds while kill high even with go high
        go = 1'b1;
        step();
        step();
        kill = 1'b1;
        seen = 0;
        for (int j = 0; j < 2 * N + 2; j++) begin
            step();
            if (done) seen++;
        end
        check(seen == 0, "R5 halt holds", seen, 0);
        kill = 1'b0;
        wait_done(lat);
        go = 1'b0;
        check(lat == N + 2, "R5 release latency", lat, N + 2);
        step();
        check(done == 1'b0, "R5 pulse width", done, 0);
        step();

        // R7: go held high, pulse period
        go = 1'b1;
        wait_done(lat);
        check(lat == N + 1, "R7 first latency", lat, N + 1);
        for (int r = 0; r < 3; r++) begin
            wait_done(lat);
            check(lat == N + 2, "R7 period", lat, N + 2);
        end
        go = 1'b0;
        repeat (2 * N + 4) step();
        check(done == 1'b0, "R7 quiet after release", done, 0);

        // R1: reset in the middle of a run
        go = 1'b1;
        step();
        go = 1'b0;
        repeat (3) step();
        rst = 1'b1;
        step();
        check(done == 1'b0, "R1 mid-run reset", done, 0);
        rst = 1'b0;
        seen = 0;
        for (int j = 0; j < 2 * N; j++) begin
            step();
            if (done) seen++;
        end
        check(seen == 0, "R1 run discarded", seen, 0);
        start_measure(lat);
        check(lat == N + 1, "R1 run after reset", lat, N + 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule